// File: doc/BRIEF.md
# Multimode 16-bit Timer/Counter

This block holds a pair of 8-bit count registers (a low byte and a high byte) that are arranged in one of four ways by a 2-bit mode field. The two bytes can run as two separate timers, or as a timer beside an event counter. They can also be chained into a single 16-bit timer or a single 16-bit event counter. Timers advance on a strobe from a two-stage prescaler. The first stage divides the cycle-rate enable by four. The second stage divides further by a programmable 8-bit reload value. Event counting advances on each rising edge of an already-synchronized input.

Each byte has a match register. When a count step arrives while the byte equals its match value, the byte returns to zero instead of incrementing, and that byte's interrupt output pulses for one cycle. In the chained modes, both halves are compared together and only the high interrupt is used. The prescaler strobe is also brought out so that other blocks can share it. Software programs the block through a small write port that selects one of four targets.

Top module: `mtc_timer16`

## Requirements
- R1: While `run` is high and no clearing write occurs, `pre_tick` pulses for exactly one cycle on every 4*(P+1)-th cycle in which `cyc_en` is high, where P is the prescaler reload. The first pulse comes on the 4*(P+1)-th enabled cycle after a clear.
- R2: In mode 2'b00, each byte steps on `pre_tick`. A step taken while the byte equals its match value loads zero, and that byte's interrupt (`irq_lo` or `irq_hi`) is high in the following cycle. Any other step adds one.
- R3: In mode 2'b01, the low byte behaves as in R2. The high byte instead steps on a rising event: `evt_in` is high in a cycle and was low in the previous cycle, with the previous sample tracked in every cycle.
- R4: In mode 2'b10, {high,low} form one 16-bit count that steps on `pre_tick`, with a carry from the low byte into the high byte at 0xFF. A step taken while both bytes equal their match values loads zero and raises `irq_hi` in the next cycle. `irq_lo` stays low.
- R5: In mode 2'b11, the 16-bit count of R4 steps on rising events of `evt_in` (as defined in R3) instead of `pre_tick`.
- R6: When `wr_en` is high, `wr_sel` selects the write target: 2'b00 low match, 2'b01 high match, 2'b10 prescaler reload, 2'b11 mode (taken from `wr_data[1:0]`). The new value takes effect from the next cycle.
- R7: A prescaler or mode write zeroes both count bytes and both prescaler stages. In that cycle, no step is taken, no interrupt is raised and `pre_tick` stays low. A match write leaves the counts and the prescaler untouched.
- R8: While `run` is low, the prescaler and both bytes hold their values, `pre_tick` and both interrupts stay low, and event edges are not counted.
- R9: After reset, the mode is 2'b00, the prescaler reload is 0, both match registers are all ones, all counts are zero and all outputs are low.
- R10: Each interrupt pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Cycle-rate enable that feeds the fixed prescaler stage |
| evt_in | input | 1 | Synchronized external event level |
| run | input | 1 | Run enable for the prescaler and the counts |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target select (see R6) |
| wr_data | input | 8 | Write data |
| irq_lo | output | 1 | Low-byte match interrupt pulse |
| irq_hi | output | 1 | High-byte or 16-bit match interrupt pulse |
| pre_tick | output | 1 | Programmable prescaler output strobe |

## Verification
The bench is aimed at the carry from 0xFF into the high byte in the chained modes. A design that mishandled it would either wrap the 16-bit count early or fire `irq_hi` at a low-byte match alone. The bench also checks that a match write in the middle of a run does not clear the counts, which a design that over-cleared on every write would. It checks that an event edge arriving while `run` is low, or during a clearing write, is dropped rather than counted later. Finally, it checks the prescaler phase after a clear: an off-by-one in either stage would shift every interrupt, and the per-cycle comparison catches this at the first strobe.

// File: rtl/mtc_pkg.sv
// Shared encodings for the multimode timer/counter.
package mtc_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,   // two 8-bit timers
        MODE_MIXED  = 2'b01,   // low timer, high event counter
        MODE_CHAIN  = 2'b10,   // 16-bit timer
        MODE_CHAINE = 2'b11    // 16-bit event counter
    } mtc_mode_e;

    localparam logic [1:0] SEL_MATCH_LO = 2'b00;
    localparam logic [1:0] SEL_MATCH_HI = 2'b01;
    localparam logic [1:0] SEL_PRESCALE = 2'b10;
    localparam logic [1:0] SEL_MODE     = 2'b11;
endpackage

// File: rtl/mtc_prescaler.sv
// Two-stage prescaler: a fixed 2^FIX_W divider on cyc_en followed by a
// programmable divide-by-(reload+1) stage. Assumes reload is stable except
// in cycles where clr is raised by the owner.
module mtc_prescaler #(
    parameter int FIX_W  = 2,
    parameter int PROG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cyc_en,
    input  logic              clr,
    input  logic [PROG_W-1:0] reload,
    output logic              tick
);
    logic [FIX_W-1:0]  fix_q;
    logic [PROG_W-1:0] prog_q;
    logic              fix_wrap;

    // Fixed stage completes a period on its all-ones state.
    always_comb fix_wrap = run && cyc_en && !clr && (fix_q == '1);

    // Output strobe when both stages complete together.
    always_comb tick = fix_wrap && (prog_q == reload);

    // Fixed stage counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       fix_q <= '0;
        else if (run && cyc_en)  fix_q <= fix_q + 1'b1;
    end

    // Programmable stage counter, reloads to zero after reaching reload.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       prog_q <= '0;
        else if (fix_wrap)       prog_q <= (prog_q == reload) ? '0 : prog_q + 1'b1;
    end

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r7_prescale_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fix_q == '0 && prog_q == '0));
endmodule

// File: rtl/mtc_edge_rise.sv
// Rising-edge detector for an input already synchronized to clk.
// The previous sample is kept every cycle regardless of run state.
module mtc_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    // Remember the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // Edge when high now and low one cycle ago.
    always_comb rise = sig && !prev_q;

    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mtc_byte_cnt.sv
// One count byte. clr has priority, then wrap (load zero), then inc.
// Assumes the owner asserts wrap only together with a step.
module mtc_byte_cnt #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wrap,
    input  logic          inc,
    output logic [BW-1:0] val
);
    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) val <= '0;
        else if (wrap)     val <= '0;
        else if (inc)      val <= val + 1'b1;
    end

    a_r7_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (val == '0));
endmodule

// File: rtl/mtc_timer16.sv
// Multimode 16-bit timer/counter top. Holds configuration registers, routes
// prescaler strobes or event edges to the two count bytes according to the
// mode, and raises one-cycle match interrupts. Inputs are assumed synchronous.
module mtc_timer16
    import mtc_pkg::*;
#(
    parameter int BW        = 8,
    parameter int PRE_FIX_W = 2,
    parameter int PRE_W     = 8,
    localparam int DW       = (BW > PRE_W) ? BW : PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_en,
    input  logic          evt_in,
    input  logic          run,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          irq_lo,
    output logic          irq_hi,
    output logic          pre_tick
);
    localparam int LANES = 2;

    mtc_mode_e        mode_q;
    logic [PRE_W-1:0] psc_q;
    logic [BW-1:0]    mlo_q, mhi_q;
    logic             clr, rise, chained;
    logic             lo_src, hi_src, lo_hit, hi_hit, full_hit;
    logic [BW-1:0]    lo_val, hi_val;
    logic [BW-1:0]    lane_val  [LANES];
    logic             lane_inc  [LANES];
    logic             lane_wrap [LANES];

    // Prescale and mode writes restart everything.
    always_comb clr = wr_en && (wr_sel == SEL_PRESCALE || wr_sel == SEL_MODE);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SPLIT;
            psc_q  <= '0;
            mlo_q  <= '1;
            mhi_q  <= '1;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MATCH_LO: mlo_q  <= wr_data[BW-1:0];
                SEL_MATCH_HI: mhi_q  <= wr_data[BW-1:0];
                SEL_PRESCALE: psc_q  <= wr_data[PRE_W-1:0];
                default:      mode_q <= mtc_mode_e'(wr_data[1:0]);
            endcase
        end
    end

    mtc_prescaler #(.FIX_W(PRE_FIX_W), .PROG_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .cyc_en(cyc_en),
        .clr(clr), .reload(psc_q), .tick(pre_tick)
    );

    mtc_edge_rise u_edge (.clk(clk), .rst_n(rst_n), .sig(evt_in), .rise(rise));

    // Step sources per byte chosen by mode.
    always_comb begin
        chained = mode_q[1];
        lo_src  = !clr && ((mode_q == MODE_CHAINE) ? (run && rise) : pre_tick);
        hi_src  = !clr && ((mode_q == MODE_MIXED || mode_q == MODE_CHAINE)
                           ? (run && rise) : pre_tick);
    end

    // Match detection for split and chained arrangements.
    always_comb begin
        lo_hit   = lo_src && (lo_val == mlo_q);
        hi_hit   = hi_src && (hi_val == mhi_q);
        full_hit = lo_src && (lo_val == mlo_q) && (hi_val == mhi_q);
    end

    // Lane controls: low byte carries into high byte when chained.
    always_comb begin
        lane_inc[0]  = lo_src;
        lane_wrap[0] = chained ? full_hit : lo_hit;
        lane_inc[1]  = chained ? (lo_src && lo_val == '1) : hi_src;
        lane_wrap[1] = chained ? full_hit : hi_hit;
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            mtc_byte_cnt #(.BW(BW)) u_byte (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .wrap(lane_wrap[g]), .inc(lane_inc[g]), .val(lane_val[g])
            );
        end
    endgenerate

    always_comb begin
        lo_val = lane_val[0];
        hi_val = lane_val[1];
    end

    // Interrupt pulses registered one cycle after the matching step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= !chained && lo_hit;
            irq_hi <= chained ? full_hit : hi_hit;
        end
    end

    a_r10_irq_lo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |=> !irq_lo);
    a_r10_irq_hi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |=> !irq_hi);
    a_r4_chain_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |-> !irq_lo);
    a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> ($stable(lo_val) && $stable(hi_val)));
    a_r2_hi_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> $past(hi_val == mhi_q));
    a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pre_tick);
endmodule

// File: tb/mtc_timer16_bench.sv
module mtc_timer16_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, evt_in = 1'b0, run = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic       irq_lo, irq_hi, pre_tick;

    int checks = 0, errors = 0;
    int n_irq_lo = 0, n_irq_hi = 0, n_tick = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mtc_timer16 u_mtc_timer16 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_in(evt_in), .run(run),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .pre_tick(pre_tick)
    );

    // Behavioural reference state.
    int m_mode, m_psc, m_mlo, m_mhi, m_fix, m_prog, m_lo, m_hi;
    bit m_prev, m_irql, m_irqh;

    function automatic string mode_tag(int md);
        case (md)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic bit exp_tick();
        bit clr_now = wr_en && (wr_sel >= 2);
        return run && cyc_en && !clr_now && m_fix == 3 && m_prog == m_psc;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, stepped on each edge and compared 2 ns later.
    always @(posedge clk) begin
        bit clr_now, rise_now, tk, lo_step, hi_step, nl, nh;
        int v;
        if (!rst_n) begin
            m_mode = 0; m_psc = 0; m_mlo = 255; m_mhi = 255;
            m_fix = 0; m_prog = 0; m_lo = 0; m_hi = 0;
            m_prev = 0; m_irql = 0; m_irqh = 0;
        end else begin
            clr_now  = wr_en && (wr_sel >= 2);
            rise_now = evt_in && !m_prev;
            m_prev   = evt_in;
            tk       = exp_tick();
            nl = 0; nh = 0;
            if (clr_now) begin
                m_fix = 0; m_prog = 0; m_lo = 0; m_hi = 0;
            end else if (run) begin
                if (cyc_en) begin
                    if (m_fix == 3) begin
                        m_fix = 0;
                        m_prog = (m_prog == m_psc) ? 0 : m_prog + 1;
                    end else m_fix++;
                end
                lo_step = (m_mode == 3) ? rise_now : tk;
                hi_step = (m_mode == 1 || m_mode == 3) ? rise_now : tk;
                if (m_mode >= 2) begin
                    v = m_hi * 256 + m_lo;
                    if (lo_step) begin
                        if (v == m_mhi * 256 + m_mlo) begin v = 0; nh = 1; end
                        else v = (v + 1) % 65536;
                    end
                    m_hi = v / 256; m_lo = v % 256;
                end else begin
                    if (lo_step) begin
                        if (m_lo == m_mlo) begin m_lo = 0; nl = 1; end
                        else m_lo = (m_lo + 1) % 256;
                    end
                    if (hi_step) begin
                        if (m_hi == m_mhi) begin m_hi = 0; nh = 1; end
                        else m_hi = (m_hi + 1) % 256;
                    end
                end
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_mlo = wr_data;
                    2'd1: m_mhi = wr_data;
                    2'd2: m_psc = wr_data;
                    default: m_mode = wr_data[1:0];
                endcase
            end
            m_irql = nl; m_irqh = nh;
        end
        #2;
        if (rst_n && !done) begin
            check({"R1 pre_tick"}, pre_tick, exp_tick());
            check({mode_tag(m_mode), " irq_lo"}, irq_lo, m_irql);
            check({mode_tag(m_mode), " irq_hi"}, irq_hi, m_irqh);
            n_irq_lo += irq_lo; n_irq_hi += irq_hi; n_tick += pre_tick;
        end
    end

    task automatic write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive random cyc_en (pct percent high) and random event levels.
    task automatic stir(input int n, input int pct, input bit evt_rand);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_en = ($urandom % 100) < pct;
            if (evt_rand) evt_in = $urandom % 2;
        end
    endtask

    task automatic clear_counts();
        n_irq_lo = 0; n_irq_hi = 0; n_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state visible at the outputs.
        check("R9 irq_lo after reset", irq_lo, 0);
        check("R9 irq_hi after reset", irq_hi, 0);
        check("R9 pre_tick after reset", pre_tick, 0);

        // R9: defaults give period 256 ticks of 4 cycles on both bytes.
        clear_counts();
        run = 1'b1;
        stir(1100, 100, 0);
        check("R9 default low period", n_irq_lo, 1);
        check("R9 default high period", n_irq_hi, 1);
        check("R1 tick count at /4", n_tick > 270 ? 1 : 0, 1);

        // R2 / R6: split timers with prescaler and matches.
        write(2'd2, 8'd1);
        write(2'd0, 8'd3);
        write(2'd1, 8'd6);
        clear_counts();
        stir(1500, 80, 1);
        check("R2 low irq seen", n_irq_lo > 0, 1);
        check("R2 high irq seen", n_irq_hi > 0, 1);

        // R7: match write mid-run does not restart (model compares each cycle).
        write(2'd0, 8'd5);
        stir(400, 100, 1);

        // R3: mixed mode with event-driven high byte.
        write(2'd3, 8'd1);
        write(2'd1, 8'd4);
        clear_counts();
        stir(1200, 70, 1);
        check("R3 event irq seen", n_irq_hi > 0, 1);

        // R8: run low freezes everything.
        run = 1'b0;
        clear_counts();
        stir(200, 100, 1);
        check("R8 no tick while stopped", n_tick, 0);
        check("R8 no irq while stopped", n_irq_lo + n_irq_hi, 0);
        run = 1'b1;

        // R4: chained timer across the low-byte carry.
        write(2'd2, 8'd0);
        write(2'd3, 8'd2);
        write(2'd0, 8'h10);
        write(2'd1, 8'h01);
        clear_counts();
        stir(2400, 100, 1);
        check("R4 chained irq_hi count", n_irq_hi, 2);
        check("R4 irq_lo silent", n_irq_lo, 0);

        // R5: chained event counter.
        write(2'd0, 8'h05);
        write(2'd1, 8'h00);
        write(2'd3, 8'd3);
        clear_counts();
        stir(600, 50, 1);
        check("R5 event chain irq seen", n_irq_hi > 0, 1);
        check("R5 irq_lo silent", n_irq_lo, 0);

        // R7: repeated clearing writes interleaved with runs.
        for (int k = 0; k < 4; k++) begin
            write(2'd2, 8'(k));
            stir(150, 90, 1);
            write(2'd3, 8'(k));
            stir(150, 90, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule